// File: doc/BRIEF.md
# Dual-Channel Phase Accumulator Upset Monitor

The block runs two phase accumulators side by side, one for channel A and one for channel B. Each channel has its own table of four frequency/phase word pairs, and its own 2-bit select picks the pair in use. The host loads the same values into entry n of both tables. Different entries of one table may still hold different values. Both accumulators then follow the same trajectory, and the block compares them on every clock cycle to catch a corruption of either one.

A synchronization event loads both accumulators with their selected phase words. A configuration input chooses which of two pulse inputs acts as this event: the system reference pulse or the start of the lane alignment sequence. Checking is armed only after such an event. It stays off while the two selects disagree, because the channels are then expected to drift apart.

Any armed cycle in which the accumulators differ sets a sticky upset flag. The flag stays set until the host writes 1 to clear it. A test input flips one chosen bit of channel B's accumulator, so that the detection path can be exercised on purpose.

Top module: `nco_pair_upset_mon`

## Requirements
- R1: A table write (cfg_wr_en=1) stores cfg_freq and cfg_phase into entry cfg_idx of channel A when cfg_chan=0, or of channel B when cfg_chan=1. The stored values are used from the next clock edge on.
- R2: The sync event is sysref_in when sync_src_sel=0 and lane_align_start when sync_src_sel=1. The input that is not selected has no effect. On an edge with the sync event high, each accumulator loads the phase word of its selected entry.
- R3: On every other edge, each accumulator adds the frequency word of its selected entry, modulo 2^32.
- R4: chk_armed is 0 after reset and before the first sync event. It is 0 on the edge that sees a sync event. It becomes 1 on the following edge, provided sel_a equals sel_b.
- R5: If chk_armed=1, sel_a equals sel_b and acc_a differs from acc_b during a cycle, upset_flag is 1 after the next edge. A single cycle of difference is enough.
- R6: upset_flag stays 1 until an edge with upset_clr=1 and no mismatch condition (R5) in that cycle. When both are present on the same edge, setting wins.
- R7: An edge with sel_a different from sel_b drives chk_armed to 0. It stays 0 until the next sync event taken while the selects are equal, so that drift during the split never raises the flag.
- R8: flip_en=1 inverts bit flip_idx of channel B's next accumulator value on that edge. Channel A is not affected.
- R9: With rst_n=0 on an edge, both accumulators, all table entries, chk_armed and upset_flag become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_chan | input | 1 | Table to write: 0 = channel A, 1 = channel B |
| cfg_idx | input | 2 | Entry index to write |
| cfg_freq | input | 32 | Frequency word to store |
| cfg_phase | input | 32 | Phase word to store |
| sel_a | input | 2 | Entry select, channel A |
| sel_b | input | 2 | Entry select, channel B |
| sync_src_sel | input | 1 | Sync source: 0 = sysref_in, 1 = lane_align_start |
| sysref_in | input | 1 | System reference pulse |
| lane_align_start | input | 1 | Lane alignment sequence start pulse |
| upset_clr | input | 1 | Write-1 clear of the upset flag |
| flip_en | input | 1 | Test: flip one bit of channel B's accumulator |
| flip_idx | input | 5 | Bit position flipped by flip_en |
| acc_a | output | 32 | Channel A accumulator |
| acc_b | output | 32 | Channel B accumulator |
| chk_armed | output | 1 | Comparison currently active |
| upset_flag | output | 1 | Sticky upset indication |

## Verification
In normal use the two accumulators never disagree, so a real upset cannot happen on its own. The bench creates one with the bit-flip input once checking is armed. It then proves that the flag survives a resync that realigns the accumulators, and that only then does a write-1 clear take effect. Two further cases need care in the stimulus. The first is a clear issued in the same cycle as a live mismatch. The second is a period with split selects followed by a return to equal selects without a new sync, where the bench checks that the drifted accumulators stay unflagged. A cycle-level model of the requirements in the bench follows every edge, so each output is compared after each step.

// File: rtl/nco_mon_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and the word-pair type of the upset monitor.
// Assumes: power-of-two entry count.
package nco_mon_pkg;
    localparam int unsigned ACC_W   = 32;
    localparam int unsigned ENTRIES = 4;
    localparam int unsigned SEL_W   = $clog2(ENTRIES);
    localparam int unsigned BIT_W   = $clog2(ACC_W);

    typedef struct packed {
        logic [ACC_W-1:0] freq;
        logic [ACC_W-1:0] phase;
    } word_pair_t;
endpackage

// File: rtl/nco_word_bank.sv
`timescale 1ns/1ps
// Module: table of frequency/phase word pairs for one channel.
// Writes are synchronous. The read of the selected entry is combinational.
// Assumes: wr_idx and rd_idx are always below ENT.
module nco_word_bank #(
    parameter int unsigned W   = 32,
    parameter int unsigned ENT = 4,
    localparam int unsigned SW = $clog2(ENT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_idx,
    input  logic [W-1:0]  wr_freq,
    input  logic [W-1:0]  wr_phase,
    input  logic [SW-1:0] rd_idx,
    output logic [W-1:0]  rd_freq,
    output logic [W-1:0]  rd_phase
);
    logic [W-1:0] freq_q  [ENT];
    logic [W-1:0] phase_q [ENT];

    for (genvar e = 0; e < ENT; e++) begin : g_entry
        // Store one entry on a matching write; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                freq_q[e]  <= '0;
                phase_q[e] <= '0;
            end else if (wr_en && (wr_idx == SW'(e))) begin
                freq_q[e]  <= wr_freq;
                phase_q[e] <= wr_phase;
            end
        end
    end

    // Present the selected entry.
    always_comb begin
        rd_freq  = freq_q[rd_idx];
        rd_phase = phase_q[rd_idx];
    end

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (freq_q[$past(wr_idx)] == $past(wr_freq))) else $error("write lost"); // R1
endmodule

// File: rtl/nco_phase_acc.sv
`timescale 1ns/1ps
// Module: one phase accumulator.
// On a sync edge it loads the phase word; on any other edge it adds the
// frequency word. The optional flip inverts one bit of the next value.
// Assumes: the flip is tied off for channels that are not tested.
module nco_phase_acc #(
    parameter int unsigned W  = 32,
    localparam int unsigned BW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_evt,
    input  logic [W-1:0]  freq,
    input  logic [W-1:0]  phase,
    input  logic          flip_en,
    input  logic [BW-1:0] flip_idx,
    output logic [W-1:0]  acc_q
);
    logic [W-1:0] nxt_base;
    logic [W-1:0] flip_mask;

    // Choose between reload and step, and build the test flip mask.
    always_comb begin
        nxt_base  = sync_evt ? phase : (acc_q + freq);
        flip_mask = flip_en ? ({{(W-1){1'b0}}, 1'b1} << flip_idx) : '0;
    end

    // Register the next accumulator value.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= nxt_base ^ flip_mask;
    end

    AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_evt && !flip_en) |=> (acc_q == $past(phase))) else $error("reload"); // R2
    AST_STEP_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_evt && !flip_en) |=> (acc_q - $past(acc_q) == $past(freq))) else $error("step"); // R3
    AST_FLIP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        flip_en |=> ($countones(acc_q ^ $past(nxt_base)) == 1)) else $error("flip"); // R8
endmodule

// File: rtl/nco_upset_cmp.sv
`timescale 1ns/1ps
// Module: arming logic and sticky upset flag.
// Arming needs a sync event taken with equal selects. It waits one edge
// after the reload and is dropped by any split of the selects.
// Assumes: sync_evt has already been chosen from its source.
module nco_upset_cmp #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_evt,
    input  logic         sel_eq,
    input  logic [W-1:0] acc_a,
    input  logic [W-1:0] acc_b,
    input  logic         clr,
    output logic         armed,
    output logic         upset_flag
);
    logic synced_q;
    logic mismatch;

    // Live mismatch, counted only when armed with equal selects.
    always_comb mismatch = armed && sel_eq && (acc_a != acc_b);

    // Remember a sync event taken with equal selects; drop it on any split.
    always_ff @(posedge clk) begin
        if (!rst_n)        synced_q <= 1'b0;
        else if (sync_evt) synced_q <= sel_eq;
        else if (!sel_eq)  synced_q <= 1'b0;
    end

    // Arm one edge after the reload while the selects stay equal.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= !sync_evt && synced_q && sel_eq;
    end

    // Sticky flag: a mismatch sets it, write-1 clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        upset_flag <= 1'b0;
        else if (mismatch) upset_flag <= 1'b1;
        else if (clr)      upset_flag <= 1'b0;
    end

    AST_SYNC_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |=> !armed) else $error("armed on reload"); // R4
    AST_MISMATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && sel_eq && (acc_a != acc_b)) |=> upset_flag) else $error("missed"); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (upset_flag && !clr) |=> upset_flag) else $error("flag dropped"); // R6
    AST_SPLIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_eq |=> !armed) else $error("armed while split"); // R7
endmodule

// File: rtl/nco_pair_upset_mon.sv
`timescale 1ns/1ps
// Module: top of the dual-channel accumulator upset monitor.
// Builds one word table and one accumulator per channel, selects the sync
// source and feeds both accumulators to the comparator.
// Assumes: the host keeps entry n equal in both tables.
module nco_pair_upset_mon
    import nco_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic             cfg_chan,
    input  logic [SEL_W-1:0] cfg_idx,
    input  logic [ACC_W-1:0] cfg_freq,
    input  logic [ACC_W-1:0] cfg_phase,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    input  logic             sync_src_sel,
    input  logic             sysref_in,
    input  logic             lane_align_start,
    input  logic             upset_clr,
    input  logic             flip_en,
    input  logic [BIT_W-1:0] flip_idx,
    output logic [ACC_W-1:0] acc_a,
    output logic [ACC_W-1:0] acc_b,
    output logic             chk_armed,
    output logic             upset_flag
);
    localparam int unsigned NCH = 2;

    logic             sync_evt;
    logic             sel_eq;
    logic [SEL_W-1:0] sel_ch [NCH];
    logic [ACC_W-1:0] acc_ch [NCH];
    word_pair_t       pair_ch [NCH];

    // Pick the sync source and compare the selects.
    always_comb begin
        sync_evt  = sync_src_sel ? lane_align_start : sysref_in;
        sel_eq    = (sel_a == sel_b);
        sel_ch[0] = sel_a;
        sel_ch[1] = sel_b;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        nco_word_bank #(.W(ACC_W), .ENT(ENTRIES)) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_wr_en && (cfg_chan == 1'(c))),
            .wr_idx   (cfg_idx),
            .wr_freq  (cfg_freq),
            .wr_phase (cfg_phase),
            .rd_idx   (sel_ch[c]),
            .rd_freq  (pair_ch[c].freq),
            .rd_phase (pair_ch[c].phase)
        );

        nco_phase_acc #(.W(ACC_W)) i_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_evt (sync_evt),
            .freq     (pair_ch[c].freq),
            .phase    (pair_ch[c].phase),
            .flip_en  (flip_en && (c == 1)),
            .flip_idx (flip_idx),
            .acc_q    (acc_ch[c])
        );
    end

    nco_upset_cmp #(.W(ACC_W)) i_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_evt   (sync_evt),
        .sel_eq     (sel_eq),
        .acc_a      (acc_ch[0]),
        .acc_b      (acc_ch[1]),
        .clr        (upset_clr),
        .armed      (chk_armed),
        .upset_flag (upset_flag)
    );

    // Bring the accumulators out.
    always_comb begin
        acc_a = acc_ch[0];
        acc_b = acc_ch[1];
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (acc_a == '0 && acc_b == '0 && !chk_armed && !upset_flag)) else $error("reset"); // R9
endmodule

// File: tb/test_nco_pair_upset_mon.sv
`timescale 1ns/1ps
// Directed bench. A cycle model of the requirements is stepped alongside
// the design, and each scenario task checks its own results.
module test_nco_pair_upset_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_chan = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_freq = '0, cfg_phase = '0;
    logic [1:0]  sel_a = '0, sel_b = '0;
    logic        sync_src_sel = 1'b0, sysref_in = 1'b0, lane_align_start = 1'b0;
    logic        upset_clr = 1'b0, flip_en = 1'b0;
    logic [4:0]  flip_idx = '0;
    logic [31:0] acc_a, acc_b;
    logic        chk_armed, upset_flag;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // model state
    logic [31:0] mf [2][4];
    logic [31:0] mp [2][4];
    logic [31:0] ma = '0, mb = '0;
    logic        m_seen = 1'b0, m_arm = 1'b0, m_flag = 1'b0;

    always #4 clk = ~clk;

    nco_pair_upset_mon i_nco_pair_upset_mon (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_chan(cfg_chan),
        .cfg_idx(cfg_idx), .cfg_freq(cfg_freq), .cfg_phase(cfg_phase),
        .sel_a(sel_a), .sel_b(sel_b), .sync_src_sel(sync_src_sel),
        .sysref_in(sysref_in), .lane_align_start(lane_align_start),
        .upset_clr(upset_clr), .flip_en(flip_en), .flip_idx(flip_idx),
        .acc_a(acc_a), .acc_b(acc_b), .chk_armed(chk_armed), .upset_flag(upset_flag)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one edge: update the model from the driven inputs, then wait.
    task automatic tick();
        logic sy, seq, mm;
        logic [31:0] na, nb;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++)
                for (int e = 0; e < 4; e++) begin mf[c][e] = '0; mp[c][e] = '0; end
            ma = '0; mb = '0; m_seen = 0; m_arm = 0; m_flag = 0;
        end else begin
            sy  = sync_src_sel ? lane_align_start : sysref_in;
            seq = (sel_a == sel_b);
            mm  = m_arm && seq && (ma != mb);
            na  = sy ? mp[0][sel_a] : ma + mf[0][sel_a];
            nb  = (sy ? mp[1][sel_b] : mb + mf[1][sel_b]) ^ (flip_en ? (32'd1 << flip_idx) : 32'd0);
            m_flag = mm | (m_flag & ~upset_clr);
            m_arm  = !sy && m_seen && seq;
            m_seen = sy ? seq : (seq ? m_seen : 1'b0);
            ma = na; mb = nb;
            if (cfg_wr_en) begin mf[cfg_chan][cfg_idx] = cfg_freq; mp[cfg_chan][cfg_idx] = cfg_phase; end
        end
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        chk(acc_a == ma, {tag, " acc_a"}, acc_a, ma);
        chk(acc_b == mb, {tag, " acc_b"}, acc_b, mb);
        chk(chk_armed == m_arm, {tag, " armed"}, 32'(chk_armed), 32'(m_arm));
        chk(upset_flag == m_flag, {tag, " flag"}, 32'(upset_flag), 32'(m_flag));
    endtask

    task automatic wr_pair(input bit ch, input logic [1:0] idx, input logic [31:0] f, input logic [31:0] p);
        cfg_wr_en = 1; cfg_chan = ch; cfg_idx = idx; cfg_freq = f; cfg_phase = p;
        tick();
        cfg_wr_en = 0;
    endtask

    task automatic pulse_sync(input bit use_align);
        if (use_align) lane_align_start = 1; else sysref_in = 1;
        tick();
        lane_align_start = 0; sysref_in = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; tick(); tick();
        chk(acc_a == 0 && acc_b == 0, "R9 accumulators zero", acc_a, 0);
        chk(!chk_armed && !upset_flag, "R9 armed/flag zero", {chk_armed, upset_flag}, 0);
        rst_n = 1; tick();
        check_all("R9 after release");
    endtask

    task automatic t_unarmed_flip();
        // R4: no sync yet, so a flip must not raise the flag
        flip_en = 1; flip_idx = 5'd3; tick(); flip_en = 0;
        tick(); tick();
        chk(upset_flag == 0, "R4 unarmed flip ignored", 32'(upset_flag), 0);
        check_all("R8 unarmed flip");
    endtask

    task automatic t_load_tables();
        for (int e = 0; e < 4; e++) begin
            wr_pair(0, 2'(e), 32'h0100_0000 * (e + 1) + 32'h35, 32'h1000_0000 + 32'(e) * 32'h111);
            wr_pair(1, 2'(e), 32'h0100_0000 * (e + 1) + 32'h35, 32'h1000_0000 + 32'(e) * 32'h111);
        end
        check_all("R1 tables loaded");
    endtask

    task automatic t_sync_sysref();
        sync_src_sel = 0; sel_a = 2'd2; sel_b = 2'd2;
        pulse_sync(0);
        chk(acc_a == 32'h1000_0222, "R1 R2 sysref reload", acc_a, 32'h1000_0222);
        chk(chk_armed == 0, "R4 not armed on reload edge", 32'(chk_armed), 0);
        tick();
        chk(chk_armed == 1, "R4 armed next edge", 32'(chk_armed), 1);
        chk(acc_a == 32'h1300_0257, "R3 one step", acc_a, 32'h1300_0257);
        for (int i = 0; i < 5; i++) tick();
        check_all("R3 accumulate");
    endtask

    task automatic t_ignored_source();
        // R2: sync_src_sel=0, so lane_align_start is ignored
        pulse_sync(1);
        check_all("R2 unselected source ignored");
        chk(acc_a != 32'h1000_0222, "R2 no reload from other source", acc_a, 32'h1000_0222);
        sync_src_sel = 1; sel_a = 2'd1; sel_b = 2'd1;
        pulse_sync(0);
        check_all("R2 sysref ignored when align chosen");
        pulse_sync(1);
        chk(acc_b == 32'h1000_0111, "R2 align start reload", acc_b, 32'h1000_0111);
        tick(); check_all("R4 armed after align sync");
    endtask

    task automatic t_flip_detect();
        flip_en = 1; flip_idx = 5'd7; tick(); flip_en = 0;
        chk((acc_a ^ acc_b) == 32'h80, "R8 bit 7 of B flipped", acc_a ^ acc_b, 32'h80);
        tick();
        chk(upset_flag == 1, "R5 single flip sets flag", 32'(upset_flag), 1);
        pulse_sync(1);
        chk(upset_flag == 1, "R6 flag held across resync", 32'(upset_flag), 1);
        check_all("R6 after resync");
        upset_clr = 1; tick(); upset_clr = 0;
        chk(upset_flag == 0, "R6 write-1 clears", 32'(upset_flag), 0);
        tick(); check_all("R6 stays clear");
    endtask

    task automatic t_set_wins();
        flip_en = 1; flip_idx = 5'd31; tick(); flip_en = 0;
        upset_clr = 1; tick(); upset_clr = 0;
        chk(upset_flag == 1, "R6 set wins over clear", 32'(upset_flag), 1);
        pulse_sync(1); upset_clr = 1; tick(); upset_clr = 0;
        check_all("R6 cleared after realign");
    endtask

    task automatic t_split_selects();
        sel_a = 2'd3; sel_b = 2'd0;
        tick();
        chk(chk_armed == 0, "R7 split disarms", 32'(chk_armed), 0);
        for (int i = 0; i < 4; i++) tick();
        sel_b = 2'd3; tick(); tick(); tick();
        chk(acc_a != acc_b, "R7 accumulators drifted", acc_a, acc_b);
        chk(upset_flag == 0 && chk_armed == 0, "R7 no flag after rejoin", {upset_flag, chk_armed}, 0);
        pulse_sync(1); tick();
        check_all("R7 rearmed by sync");
    endtask

    task automatic t_wrap();
        wr_pair(0, 2'd0, 32'hF000_0001, 32'h2000_0000);
        wr_pair(1, 2'd0, 32'hF000_0001, 32'h2000_0000);
        sel_a = 0; sel_b = 0; pulse_sync(1); tick(); tick();
        chk(acc_a == 32'h0000_0002, "R3 wraps modulo 2^32", acc_a, 32'h0000_0002);
        check_all("R3 wrap");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_unarmed_flip();
        t_load_tables();
        t_sync_sysref();
        t_ignored_source();
        t_flip_detect();
        t_set_wins();
        t_split_selects();
        t_wrap();
        t_reset();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule